// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block takes eight interrupt request lines and turns them into one interrupt line for a processor. It also returns an 8-bit vector for the request it selects. Requests are captured in a request register, filtered by a mask, and ranked against a rotating priority order. A request reaches the processor only when it outranks every level already being serviced. On acknowledge, the controller marks the winning level as in service. It then returns a vector built from a programmed 5-bit base in the upper bits and the 3-bit level in the lower bits.

Service completion is signalled by end-of-interrupt commands, which can be non-specific or name a level. Either form can also rotate the priority order. An automatic mode instead clears the in-service bit during the acknowledge, and that mode can optionally rotate as well. A set-priority command picks the lowest-priority input directly. A poll word reports the current winner without an acknowledge. A separate decoder drives configuration and commands through the simple strobes shown below, and no bus logic sits inside the block.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After reset the request and in-service registers read 0, the mask reads 8'hFF (all masked), `irq_out` is low, `poll_word` is 0, and priority is fixed with level 0 highest and level 7 lowest.
- R2: With `cfg_level`=0 a request bit is set by a rising edge of its input. It stays set until acknowledged, and an input held high does not set it again. With `cfg_level`=1 the request register follows the inputs each cycle.
- R3: A request whose mask bit is 1 is still recorded in `irr_o`, but it neither raises `irq_out` nor appears in `poll_word`. `mask_wr` loads `mask_in`.
- R4: Among pending unmasked requests, the one earliest in the priority order wins. Under the default order this is the lowest index.
- R5: `irq_out` is high only when an unmasked request outranks every level whose in-service bit is set. A request of equal or lower rank waits until the blocking level is cleared.
- R6: A one-cycle `ack_start` pulse sets the winner's in-service bit and clears its edge-mode request bit, and `irq_out` is low in the following cycle. One cycle later `vec_valid` pulses for one cycle with `vec_out` = {base, level}. If nothing is pending, the vector uses level 7 and no in-service bit is set.
- R7: Command code 1 (non-specific EOI) clears the in-service bit of the highest-ranked level in service.
- R8: Command code 2 (specific EOI) clears the in-service bit named by `cmd_lvl`.
- R9: Command code 3 (non-specific EOI with rotate) and code 4 (specific EOI with rotate) clear the bit as R7/R8 do. The cleared level then becomes lowest priority, and the next level up becomes highest.
- R10: Command code 5 makes `cmd_lvl` the lowest-priority level without touching in-service bits.
- R11: With `cfg_auto_eoi`=1 the in-service bit set by an acknowledge is cleared on the edge that raises `vec_valid`. Priority is left unchanged, unless code 6 has enabled rotation in this mode; code 7 disables it. With rotation enabled, the acknowledged level becomes lowest priority.
- R12: `poll_word` has bit 7 set when an eligible request is pending, bits 2..0 hold its level, and bits 6..3 are 0. When bit 7 is 0 the whole word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, level 0 to 7 |
| cfg_level | input | 1 | 1 = level-sensitive requests, 0 = rising-edge |
| cfg_auto_eoi | input | 1 | 1 = automatic end of interrupt |
| base_wr | input | 1 | Load vector base |
| base_in | input | 5 | Vector base, upper five vector bits |
| mask_wr | input | 1 | Load mask |
| mask_in | input | 8 | Mask value, 1 disables a line |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R7 to R11) |
| cmd_lvl | input | 3 | Level operand for commands |
| ack_start | input | 1 | Acknowledge pulse |
| irq_out | output | 1 | Interrupt to processor |
| vec_valid | output | 1 | Vector present on `vec_out` |
| vec_out | output | 8 | Interrupt vector |
| poll_word | output | 8 | Pending flag and winning level |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| mask_o | output | 8 | Mask register |

## Verification
The properties assume that the processor never overlaps transactions. An acknowledge pulse only arrives once the previous acknowledge's vector has come out, and it never shares a cycle with a command strobe. They also assume that `cfg_auto_eoi` is not changed while in-service bits are set. The directed stimulus keeps to these rules. Every acknowledge and command is a lone one-cycle pulse followed by idle cycles, and the mode inputs are changed only when the in-service register is empty.

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       cfg_level,
  input  logic       cfg_auto_eoi,
  input  logic       base_wr,
  input  logic [4:0] base_in,
  input  logic       mask_wr,
  input  logic [7:0] mask_in,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [2:0] cmd_lvl,
  input  logic       ack_start,
  output logic       irq_out,
  output logic       vec_valid,
  output logic [7:0] vec_out,
  output logic [7:0] poll_word,
  output logic [7:0] irr_o,
  output logic [7:0] isr_o,
  output logic [7:0] mask_o
);
  localparam logic [2:0] OP_EOI      = 3'd1;
  localparam logic [2:0] OP_SEOI     = 3'd2;
  localparam logic [2:0] OP_ROT_EOI  = 3'd3;
  localparam logic [2:0] OP_ROT_SEOI = 3'd4;
  localparam logic [2:0] OP_SET_PRI  = 3'd5;
  localparam logic [2:0] OP_RAEOI_ON = 3'd6;
  localparam logic [2:0] OP_RAEOI_OF = 3'd7;

  logic [7:0] irq_q, irr, isr, mask, irr_n, isr_n;
  logic [4:0] base;
  logic [2:0] lo_pri, lo_n, ack_lvl;
  logic       rot_aeoi, ack_ph, ack_hit;
  logic       win_hit, isr_hit, pend, take;
  logic [2:0] win_k, win_lvl, isr_k, isr_lvl;
  logic [7:0] req_m;

  assign req_m = irr & ~mask;

  always_comb begin
    win_hit = 1'b0; win_k = 3'd0; win_lvl = 3'd0;
    isr_hit = 1'b0; isr_k = 3'd0; isr_lvl = 3'd0;
    for (int k = 0; k < 8; k++) begin
      if (!win_hit && req_m[lo_pri + 3'd1 + 3'(k)]) begin
        win_hit = 1'b1;
        win_k   = 3'(k);
        win_lvl = lo_pri + 3'd1 + 3'(k);
      end
      if (!isr_hit && isr[lo_pri + 3'd1 + 3'(k)]) begin
        isr_hit = 1'b1;
        isr_k   = 3'(k);
        isr_lvl = lo_pri + 3'd1 + 3'(k);
      end
    end
  end

  assign pend      = win_hit && (!isr_hit || win_k < isr_k);
  assign take      = ack_start && !ack_ph;
  assign irq_out   = pend && !ack_ph;
  assign poll_word = pend ? {1'b1, 4'b0000, win_lvl} : 8'h00;
  assign irr_o     = irr;
  assign isr_o     = isr;
  assign mask_o    = mask;

  always_comb begin
    irr_n = cfg_level ? irq_in : (irr | (irq_in & ~irq_q));
    if (!cfg_level && take && pend) irr_n[win_lvl] = 1'b0;

    isr_n = isr;
    lo_n  = lo_pri;
    if (take && pend) isr_n[win_lvl] = 1'b1;
    if (ack_ph && ack_hit && cfg_auto_eoi) begin
      isr_n[ack_lvl] = 1'b0;
      if (rot_aeoi) lo_n = ack_lvl;
    end
    if (cmd_valid) begin
      case (cmd_op)
        OP_EOI:      if (isr_hit) isr_n[isr_lvl] = 1'b0;
        OP_ROT_EOI:  if (isr_hit) begin isr_n[isr_lvl] = 1'b0; lo_n = isr_lvl; end
        OP_SEOI:     isr_n[cmd_lvl] = 1'b0;
        OP_ROT_SEOI: begin isr_n[cmd_lvl] = 1'b0; lo_n = cmd_lvl; end
        OP_SET_PRI:  lo_n = cmd_lvl;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 8'h00; irr <= 8'h00; isr <= 8'h00; mask <= 8'hFF;
      base <= 5'd0; lo_pri <= 3'd7; rot_aeoi <= 1'b0;
      ack_ph <= 1'b0; ack_hit <= 1'b0; ack_lvl <= 3'd0;
      vec_valid <= 1'b0; vec_out <= 8'h00;
    end else begin
      irq_q     <= irq_in;
      irr       <= irr_n;
      isr       <= isr_n;
      lo_pri    <= lo_n;
      vec_valid <= 1'b0;
      if (mask_wr) mask <= mask_in;
      if (base_wr) base <= base_in;
      if (cmd_valid && cmd_op == OP_RAEOI_ON) rot_aeoi <= 1'b1;
      if (cmd_valid && cmd_op == OP_RAEOI_OF) rot_aeoi <= 1'b0;
      if (take) begin
        ack_ph  <= 1'b1;
        ack_hit <= pend;
        ack_lvl <= pend ? win_lvl : 3'd7;
      end else if (ack_ph) begin
        ack_ph    <= 1'b0;
        vec_valid <= 1'b1;
        vec_out   <= {base, ack_lvl};
      end
    end
  end
endmodule

module intr_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_auto_eoi,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [2:0] cmd_lvl,
  input logic       ack_start,
  input logic       irq_out,
  input logic       vec_valid,
  input logic [7:0] vec_out,
  input logic [7:0] poll_word,
  input logic [7:0] irr_o,
  input logic [7:0] isr_o,
  input logic [7:0] mask_o
);
  p_int_drops_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |=> !irq_out);
  p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_start, 2));
  p_poll_shape_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_word[6:3] == 4'b0000) && (poll_word[7] || poll_word == 8'h00));
  p_poll_is_request_r12: assert property (@(posedge clk) disable iff (!rst_n)
    poll_word[7] |-> irr_o[poll_word[2:0]]);
  p_masked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_word[7] |-> !mask_o[poll_word[2:0]]);
  p_int_needs_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> poll_word[7]);
  p_spec_eoi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> !isr_o[$past(cmd_lvl)]);
  p_auto_eoi_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && cfg_auto_eoi && $past(cfg_auto_eoi)) |-> !isr_o[vec_out[2:0]]);
endmodule

bind intr_prio_ctrl intr_prio_ctrl_chk u_chk (.*);

// File: tb/intr_prio_ctrl_bench.sv
module intr_prio_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] irq_in = 8'h00;
  logic cfg_level = 1'b0, cfg_auto_eoi = 1'b0;
  logic base_wr = 1'b0, mask_wr = 1'b0, cmd_valid = 1'b0, ack_start = 1'b0;
  logic [4:0] base_in = 5'd0;
  logic [7:0] mask_in = 8'h00;
  logic [2:0] cmd_op = 3'd0, cmd_lvl = 3'd0;
  logic irq_out, vec_valid;
  logic [7:0] vec_out, poll_word, irr_o, isr_o, mask_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_prio_ctrl u_intr_prio_ctrl (.*);

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] lvl);
    cmd_valid = 1; cmd_op = op; cmd_lvl = lvl;
    step();
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic ack(input logic [7:0] exp_vec, input logic [7:0] isr_mid, input logic [7:0] isr_end);
    ack_start = 1;
    step();
    ack_start = 0;
    chk("R6 isr after ack", isr_o, isr_mid);
    chk("R6 irq low in ack", {7'd0, irq_out}, 8'h00);
    step();
    chk("R6 vec_valid", {7'd0, vec_valid}, 8'h01);
    chk("R6 vector", vec_out, exp_vec);
    chk("R11 R6 isr at vector", isr_o, isr_end);
    step();
    chk("R6 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 irr", irr_o, 8'h00);
    chk("R1 isr", isr_o, 8'h00);
    chk("R1 mask", mask_o, 8'hFF);
    chk("R1 irq", {7'd0, irq_out}, 8'h00);
    chk("R1 poll", poll_word, 8'h00);
  endtask

  task automatic t_mask();
    base_wr = 1; base_in = 5'h01; step(); base_wr = 0;
    irq_in = 8'h08; step();
    chk("R3 masked recorded", irr_o, 8'h08);
    chk("R3 masked no irq", {7'd0, irq_out}, 8'h00);
    chk("R3 masked no poll", poll_word, 8'h00);
    mask_wr = 1; mask_in = 8'h00; step(); mask_wr = 0;
    chk("R3 mask load", mask_o, 8'h00);
    chk("R3 unmasked irq", {7'd0, irq_out}, 8'h01);
    chk("R12 poll word", poll_word, 8'h83);
  endtask

  task automatic t_ack_eoi();
    ack(8'h0B, 8'h08, 8'h08);
    chk("R6 irr cleared", irr_o, 8'h00);
    step(); step();
    chk("R2 held high no retrigger", irr_o, 8'h00);
    irq_in = 8'h00;
    cmd(3'd1, 3'd0);
    chk("R7 nonspecific eoi", isr_o, 8'h00);
  endtask

  task automatic t_nest();
    irq_in = 8'h24; step();
    chk("R4 fixed priority", poll_word, 8'h82);
    ack(8'h0A, 8'h04, 8'h04);
    chk("R5 lower blocked", {7'd0, irq_out}, 8'h00);
    irq_in = 8'h26; step();
    chk("R5 higher nests", {7'd0, irq_out}, 8'h01);
    ack(8'h09, 8'h06, 8'h06);
    cmd(3'd1, 3'd0);
    chk("R7 clears highest only", isr_o, 8'h04);
    chk("R5 still blocked", {7'd0, irq_out}, 8'h00);
    cmd(3'd2, 3'd2);
    chk("R8 specific eoi", isr_o, 8'h00);
    chk("R5 released", {7'd0, irq_out}, 8'h01);
    ack(8'h0D, 8'h20, 8'h20);
    cmd(3'd2, 3'd5);
    irq_in = 8'h00; step();
  endtask

  task automatic t_rotate();
    irq_in = 8'h10; step();
    ack(8'h0C, 8'h10, 8'h10);
    cmd(3'd3, 3'd0);
    chk("R9 rotate eoi clears", isr_o, 8'h00);
    irq_in = 8'h00; step();
    irq_in = 8'h28; step();
    chk("R9 after level 4 lowest", poll_word, 8'h85);
    ack(8'h0D, 8'h20, 8'h20);
    cmd(3'd4, 3'd5);
    irq_in = 8'h68; step();
    chk("R9 after level 5 lowest", poll_word, 8'h86);
    ack(8'h0E, 8'h40, 8'h40);
    cmd(3'd2, 3'd6);
    cmd(3'd5, 3'd2);
    irq_in = 8'h6C; step();
    chk("R10 set lowest", poll_word, 8'h83);
    ack(8'h0B, 8'h08, 8'h08);
    cmd(3'd1, 3'd0);
    ack(8'h0A, 8'h04, 8'h04);
    cmd(3'd1, 3'd0);
    chk("R10 isr untouched then cleared", isr_o, 8'h00);
    cmd(3'd5, 3'd7);
    irq_in = 8'h00; step();
  endtask

  task automatic t_spurious();
    ack(8'h0F, 8'h00, 8'h00);
  endtask

  task automatic t_aeoi();
    cfg_auto_eoi = 1;
    irq_in = 8'h02; step();
    ack(8'h09, 8'h02, 8'h00);
    irq_in = 8'h00; step();
    irq_in = 8'h81; step();
    chk("R11 priority unchanged", poll_word, 8'h80);
    ack(8'h08, 8'h01, 8'h00);
    ack(8'h0F, 8'h80, 8'h00);
    irq_in = 8'h00;
    cmd(3'd6, 3'd0);
    irq_in = 8'h04; step();
    ack(8'h0A, 8'h04, 8'h00);
    irq_in = 8'h00; step();
    irq_in = 8'h0A; step();
    chk("R11 rotate in auto mode", poll_word, 8'h83);
    ack(8'h0B, 8'h08, 8'h00);
    ack(8'h09, 8'h02, 8'h00);
    cmd(3'd7, 3'd0);
    cmd(3'd5, 3'd7);
    irq_in = 8'h00; step();
    cfg_auto_eoi = 0;
  endtask

  task automatic t_level();
    cfg_level = 1;
    irq_in = 8'h40; step();
    chk("R2 level follows high", irr_o, 8'h40);
    irq_in = 8'h00; step();
    chk("R2 level follows low", irr_o, 8'h00);
    cfg_level = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_mask();
    t_ack_eoi();
    t_nest();
    t_rotate();
    t_spurious();
    t_aeoi();
    t_level();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule